// File: doc/BRIEF.md
# Column Command Timing Tracker

This block keeps column-command timing for one DRAM channel. For every bank of every rank it holds two earliest-issue cycles, one for reads and one for writes. It also holds the cycle from which the shared data bus can take the next burst. A scheduler sends it three kinds of event: row activates, column commands and power-down exits. It asks the block, through a combinational query port, when a read or a write to a chosen bank may legally go out.

When a column command is reported, the block first works out its actual issue cycle. It then pushes forward the read and write limits of every bank in the channel. The amount depends on whether the other bank shares the rank and the bank group, and on whether the old and the next command differ in direction. No limit ever moves earlier. All timing values are static parameters. A flag reports a configuration in which the same-group write-to-write gap does not exceed the burst length.

Top module: `col_timing_tracker`

## Requirements
- R1: After reset every counter and the next-burst cycle are zero, so every query returns its `q_now`.
- R2: `q_earliest` is the maximum of three values: the selected bank's counter for the queried direction (`q_is_wr`=1 selects write), `next_burst` and `q_now`. It is combinational.
- R3: An activate at cycle A raises both counters of the addressed bank to at least A+T_RCD, and no other bank changes.
- R4: After a column command issued at cycle C, each bank in the same rank and the same bank group (group = bank / (BANKS_PER_RANK/BANK_GROUPS)) gets these lower bounds. The read counter is C+T_CCD_L after a read, or C+max(T_CCD_L, T_CL+T_BURST+T_WTR) after a write. The write counter is C+max(T_CCD_L, T_RTW+T_BURST) after a read, or C+T_CCD_L_WR after a write.
- R5: After a column command issued at cycle C, each bank in the same rank but another bank group (or any bank of that rank when BANK_GROUPS is 1) gets these lower bounds. The read counter is C+T_BURST after a read, or C+T_CL+T_BURST+T_WTR after a write. The write counter is C+T_RTW+T_BURST after a read, or C+T_BURST after a write.
- R6: After a column command issued at cycle C, both counters of every bank in every other rank rise to at least C+T_CS+T_BURST.
- R7: A column command's issue cycle is the maximum of three values: its bank's pre-update counter for its direction, `next_burst` and `col_cycle`. `next_burst` then becomes that issue cycle plus T_BURST.
- R8: Every counter update takes the maximum with the current value, so a counter never decreases.
- R9: A power-down exit at cycle P for a rank raises both counters of every bank in that rank to at least P+T_XP. Other ranks are unchanged.
- R10: `cfg_error` is 1 exactly when BANK_GROUPS > 1 and T_CCD_L_WR <= T_BURST.
- R11: Events given in the same cycle all take effect at the next edge. Each counter becomes the largest of its own value and every bound applied to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activate event pulse |
| act_rank | input | RANK_W | Activated rank |
| act_bank | input | BANK_W | Activated bank |
| act_cycle | input | CYC_W | Cycle of the activate |
| col_valid | input | 1 | Column command event pulse |
| col_rank | input | RANK_W | Command rank |
| col_bank | input | BANK_W | Command bank |
| col_is_wr | input | 1 | 1 = write, 0 = read |
| col_cycle | input | CYC_W | Earliest cycle the scheduler wanted |
| pd_exit_valid | input | 1 | Power-down exit event pulse |
| pd_exit_rank | input | RANK_W | Rank waking up |
| pd_exit_cycle | input | CYC_W | Wake-up cycle |
| q_rank | input | RANK_W | Query rank |
| q_bank | input | BANK_W | Query bank |
| q_is_wr | input | 1 | Query direction, 1 = write |
| q_now | input | CYC_W | Current cycle for the query |
| q_earliest | output | CYC_W | Earliest legal issue cycle |
| next_burst | output | CYC_W | Next cycle the data bus is free |
| cfg_error | output | 1 | Timing configuration violation |

## Verification
Two events can land on the same clock edge. One is a column command that sweeps its delays across every bank. The other is an activate that targets one bank, and it may target the very bank the command addresses. The bench raises both valid pulses together, once with the activate in another rank and once on the command's own bank. It then queries the affected banks and expects the larger of the activate bound and the column bound. The column issue cycle must come from the counters as they stood before that edge.

// File: rtl/col_timing_pkg.sv
package col_timing_pkg;

   typedef enum logic [1:0] {
      REL_SAME_GROUP  = 2'd0,
      REL_OTHER_GROUP = 2'd1,
      REL_OTHER_RANK  = 2'd2
   } bank_rel_e;

endpackage

// File: rtl/col_delay_table.sv
module col_delay_table
   import col_timing_pkg::*;
#(
   parameter int CYC_W      = 32,
   parameter int T_BURST    = 4,
   parameter int T_CCD_L    = 6,
   parameter int T_CCD_L_WR = 8,
   parameter int T_CS       = 2,
   parameter int T_CL       = 11,
   parameter int T_WTR      = 3,
   parameter int T_RTW      = 2
) (
   input  bank_rel_e        rel,
   input  logic             prev_wr,
   output logic [CYC_W-1:0] dly_rd,
   output logic [CYC_W-1:0] dly_wr
);
   localparam int WR2RD   = T_CL + T_BURST + T_WTR;
   localparam int RD2WR   = T_RTW + T_BURST;
   localparam int XRANK   = T_CS + T_BURST;
   localparam int SG_RD_W = (T_CCD_L > WR2RD) ? T_CCD_L : WR2RD;
   localparam int SG_WR_R = (T_CCD_L > RD2WR) ? T_CCD_L : RD2WR;

   always_comb begin
      unique case (rel)
         REL_SAME_GROUP: begin
            dly_rd = prev_wr ? CYC_W'(SG_RD_W)    : CYC_W'(T_CCD_L);
            dly_wr = prev_wr ? CYC_W'(T_CCD_L_WR) : CYC_W'(SG_WR_R);
         end
         REL_OTHER_GROUP: begin
            dly_rd = prev_wr ? CYC_W'(WR2RD)   : CYC_W'(T_BURST);
            dly_wr = prev_wr ? CYC_W'(T_BURST) : CYC_W'(RD2WR);
         end
         default: begin
            dly_rd = CYC_W'(XRANK);
            dly_wr = CYC_W'(XRANK);
         end
      endcase
   end
endmodule

// File: rtl/col_max3.sv
module col_max3 #(
   parameter int CYC_W = 32
) (
   input  logic [CYC_W-1:0] a,
   input  logic [CYC_W-1:0] b,
   input  logic [CYC_W-1:0] c,
   output logic [CYC_W-1:0] y
);
   logic [CYC_W-1:0] ab;
   assign ab = (a > b) ? a : b;
   assign y  = (ab > c) ? ab : c;
endmodule

// File: rtl/bank_timer.sv
module bank_timer #(
   parameter int CYC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_hit,
   input  logic [CYC_W-1:0] act_at,
   input  logic             col_hit,
   input  logic [CYC_W-1:0] col_rd_at,
   input  logic [CYC_W-1:0] col_wr_at,
   input  logic             pd_hit,
   input  logic [CYC_W-1:0] pd_at,
   output logic [CYC_W-1:0] rd_at,
   output logic [CYC_W-1:0] wr_at
);
   logic [CYC_W-1:0] rd_n, wr_n;

   always_comb begin
      rd_n = rd_at;
      wr_n = wr_at;
      if (act_hit) begin
         if (act_at > rd_n) rd_n = act_at;
         if (act_at > wr_n) wr_n = act_at;
      end
      if (col_hit) begin
         if (col_rd_at > rd_n) rd_n = col_rd_at;
         if (col_wr_at > wr_n) wr_n = col_wr_at;
      end
      if (pd_hit) begin
         if (pd_at > rd_n) rd_n = pd_at;
         if (pd_at > wr_n) wr_n = pd_at;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_at <= '0;
         wr_at <= '0;
      end else begin
         rd_at <= rd_n;
         wr_at <= wr_n;
      end
   end
endmodule

// File: rtl/col_timing_tracker.sv
module col_timing_tracker
   import col_timing_pkg::*;
#(
   parameter int NUM_RANKS      = 2,
   parameter int BANKS_PER_RANK = 8,
   parameter int BANK_GROUPS    = 2,
   parameter int CYC_W          = 32,
   parameter int T_BURST        = 4,
   parameter int T_CCD_L        = 6,
   parameter int T_CCD_L_WR     = 8,
   parameter int T_CS           = 2,
   parameter int T_CL           = 11,
   parameter int T_WTR          = 3,
   parameter int T_RTW          = 2,
   parameter int T_RCD          = 12,
   parameter int T_XP           = 5,
   localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
   localparam int BANK_W = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_valid,
   input  logic [RANK_W-1:0] act_rank,
   input  logic [BANK_W-1:0] act_bank,
   input  logic [CYC_W-1:0]  act_cycle,
   input  logic              col_valid,
   input  logic [RANK_W-1:0] col_rank,
   input  logic [BANK_W-1:0] col_bank,
   input  logic              col_is_wr,
   input  logic [CYC_W-1:0]  col_cycle,
   input  logic              pd_exit_valid,
   input  logic [RANK_W-1:0] pd_exit_rank,
   input  logic [CYC_W-1:0]  pd_exit_cycle,
   input  logic [RANK_W-1:0] q_rank,
   input  logic [BANK_W-1:0] q_bank,
   input  logic              q_is_wr,
   input  logic [CYC_W-1:0]  q_now,
   output logic [CYC_W-1:0]  q_earliest,
   output logic [CYC_W-1:0]  next_burst,
   output logic              cfg_error
);
   localparam int NUM_BANKS  = NUM_RANKS * BANKS_PER_RANK;
   localparam int IDX_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int GRP_BANKS  = BANKS_PER_RANK / BANK_GROUPS;
   localparam logic CFG_BAD  = (BANK_GROUPS > 1) && (T_CCD_L_WR <= T_BURST);

   if (NUM_RANKS < 1 || BANKS_PER_RANK < 1 || BANK_GROUPS < 1) begin : g_bad_count
      $error("col_timing_tracker: counts must be at least 1");
   end
   if (BANKS_PER_RANK % BANK_GROUPS != 0) begin : g_bad_groups
      $error("col_timing_tracker: banks per rank must divide evenly into groups");
   end
   if (CYC_W < 8) begin : g_bad_width
      $error("col_timing_tracker: cycle width too small");
   end

   assign cfg_error = CFG_BAD;

   logic [CYC_W-1:0] rd_at [NUM_BANKS];
   logic [CYC_W-1:0] wr_at [NUM_BANKS];

   logic [IDX_W-1:0] col_idx, q_idx;
   logic [BANK_W-1:0] col_grp;
   logic [CYC_W-1:0] col_cnt, q_cnt, issue_at;
   logic [CYC_W-1:0] act_bound, pd_bound;

   assign col_idx = IDX_W'(col_rank) * IDX_W'(BANKS_PER_RANK) + IDX_W'(col_bank);
   assign q_idx   = IDX_W'(q_rank) * IDX_W'(BANKS_PER_RANK) + IDX_W'(q_bank);
   assign col_grp = col_bank / BANK_W'(GRP_BANKS);
   assign col_cnt = col_is_wr ? wr_at[col_idx] : rd_at[col_idx];
   assign q_cnt   = q_is_wr ? wr_at[q_idx] : rd_at[q_idx];
   assign act_bound = act_cycle + CYC_W'(T_RCD);
   assign pd_bound  = pd_exit_cycle + CYC_W'(T_XP);

   col_max3 #(.CYC_W(CYC_W)) u_issue (
      .a(col_cnt), .b(next_burst), .c(col_cycle), .y(issue_at)
   );

   col_max3 #(.CYC_W(CYC_W)) u_query (
      .a(q_cnt), .b(next_burst), .c(q_now), .y(q_earliest)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         next_burst <= '0;
      else if (col_valid) next_burst <= issue_at + CYC_W'(T_BURST);
   end

   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      for (genvar b = 0; b < BANKS_PER_RANK; b++) begin : g_bank
         localparam int IDX    = r * BANKS_PER_RANK + b;
         localparam int MY_GRP = b / GRP_BANKS;
         logic same_rank, same_grp;
         bank_rel_e rel;
         logic [CYC_W-1:0] d_rd, d_wr;

         assign same_rank = (col_rank == RANK_W'(r));
         if (BANK_GROUPS > 1) begin : g_grouped
            assign same_grp = (col_grp == BANK_W'(MY_GRP));
         end else begin : g_flat
            assign same_grp = 1'b0;
         end
         assign rel = !same_rank ? REL_OTHER_RANK :
                      (same_grp ? REL_SAME_GROUP : REL_OTHER_GROUP);

         col_delay_table #(
            .CYC_W(CYC_W), .T_BURST(T_BURST), .T_CCD_L(T_CCD_L),
            .T_CCD_L_WR(T_CCD_L_WR), .T_CS(T_CS), .T_CL(T_CL),
            .T_WTR(T_WTR), .T_RTW(T_RTW)
         ) u_dly (
            .rel(rel), .prev_wr(col_is_wr), .dly_rd(d_rd), .dly_wr(d_wr)
         );

         bank_timer #(.CYC_W(CYC_W)) u_timer (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_hit   (act_valid && act_rank == RANK_W'(r) && act_bank == BANK_W'(b)),
            .act_at    (act_bound),
            .col_hit   (col_valid),
            .col_rd_at (issue_at + d_rd),
            .col_wr_at (issue_at + d_wr),
            .pd_hit    (pd_exit_valid && pd_exit_rank == RANK_W'(r)),
            .pd_at     (pd_bound),
            .rd_at     (rd_at[IDX]),
            .wr_at     (wr_at[IDX])
         );
      end
   end
endmodule

// File: rtl/col_timing_tracker_chk.sv
module col_timing_tracker_chk #(
   parameter int NUM_BANKS      = 16,
   parameter int BANKS_PER_RANK = 8,
   parameter int RANK_W         = 1,
   parameter int BANK_W         = 3,
   parameter int CYC_W          = 32,
   parameter int T_BURST        = 4,
   parameter int T_RCD          = 12,
   parameter int T_XP           = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CYC_W-1:0]  rd_at [NUM_BANKS],
   input logic [CYC_W-1:0]  wr_at [NUM_BANKS],
   input logic [CYC_W-1:0]  next_burst,
   input logic              act_valid,
   input logic [RANK_W-1:0] act_rank,
   input logic [BANK_W-1:0] act_bank,
   input logic [CYC_W-1:0]  act_cycle,
   input logic              col_valid,
   input logic [CYC_W-1:0]  col_cycle,
   input logic              pd_exit_valid,
   input logic [RANK_W-1:0] pd_exit_rank,
   input logic [CYC_W-1:0]  pd_exit_cycle,
   input logic [CYC_W-1:0]  q_now,
   input logic [CYC_W-1:0]  q_earliest
);
   localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   logic [IDX_W-1:0] a_idx, p_idx;
   assign a_idx = IDX_W'(act_rank) * IDX_W'(BANKS_PER_RANK) + IDX_W'(act_bank);
   assign p_idx = IDX_W'(pd_exit_rank) * IDX_W'(BANKS_PER_RANK);

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_mono
      assert_rd_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> rd_at[i] >= $past(rd_at[i]));
      assert_wr_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> wr_at[i] >= $past(wr_at[i]));
   end

   assert_burst_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
      col_valid |=> next_burst >= $past(col_cycle) + CYC_W'(T_BURST));

   assert_act_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |=> rd_at[$past(a_idx)] >= $past(act_cycle) + CYC_W'(T_RCD)
                 && wr_at[$past(a_idx)] >= $past(act_cycle) + CYC_W'(T_RCD));

   assert_pd_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pd_exit_valid |=> rd_at[$past(p_idx)] >= $past(pd_exit_cycle) + CYC_W'(T_XP));

   assert_query_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      q_earliest >= q_now && q_earliest >= next_burst);
endmodule

bind col_timing_tracker col_timing_tracker_chk #(
   .NUM_BANKS(NUM_BANKS), .BANKS_PER_RANK(BANKS_PER_RANK), .RANK_W(RANK_W),
   .BANK_W(BANK_W), .CYC_W(CYC_W), .T_BURST(T_BURST), .T_RCD(T_RCD), .T_XP(T_XP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_at(rd_at), .wr_at(wr_at), .next_burst(next_burst),
   .act_valid(act_valid), .act_rank(act_rank), .act_bank(act_bank), .act_cycle(act_cycle),
   .col_valid(col_valid), .col_cycle(col_cycle), .pd_exit_valid(pd_exit_valid),
   .pd_exit_rank(pd_exit_rank), .pd_exit_cycle(pd_exit_cycle),
   .q_now(q_now), .q_earliest(q_earliest)
);

// File: tb/col_timing_tracker_tb.sv
module col_timing_tracker_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        act_valid = 0, col_valid = 0, pd_exit_valid = 0, col_is_wr = 0, q_is_wr = 0;
   logic [0:0]  act_rank = 0, col_rank = 0, pd_exit_rank = 0, q_rank = 0;
   logic [2:0]  act_bank = 0, col_bank = 0, q_bank = 0;
   logic [31:0] act_cycle = 0, col_cycle = 0, pd_exit_cycle = 0, q_now = 0;
   logic [31:0] q_earliest, next_burst;
   logic        cfg_error;

   col_timing_tracker u_dut (
      .clk(clk), .rst_n(rst_n),
      .act_valid(act_valid), .act_rank(act_rank), .act_bank(act_bank), .act_cycle(act_cycle),
      .col_valid(col_valid), .col_rank(col_rank), .col_bank(col_bank),
      .col_is_wr(col_is_wr), .col_cycle(col_cycle),
      .pd_exit_valid(pd_exit_valid), .pd_exit_rank(pd_exit_rank), .pd_exit_cycle(pd_exit_cycle),
      .q_rank(q_rank), .q_bank(q_bank), .q_is_wr(q_is_wr), .q_now(q_now),
      .q_earliest(q_earliest), .next_burst(next_burst), .cfg_error(cfg_error)
   );

   typedef struct { logic [31:0] exp; string req; } sb_item_t;
   sb_item_t exp_q[$];
   int n_vec = 0, n_bad = 0;
   bit done = 0;

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic query(input int r, input int b, input bit wr, input int now,
                        input int exp, input string req);
      q_rank = 1'(r); q_bank = 3'(b); q_is_wr = wr; q_now = now;
      exp_q.push_back('{exp: 32'(exp), req: req});
      tick();
   endtask

   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         sb_item_t it;
         it = exp_q.pop_front();
         n_vec++;
         if (q_earliest !== it.exp) begin
            n_bad++;
            $display("FAIL %s: q_earliest actual %0d expected %0d (rank %0d bank %0d wr %0d)",
                     it.req, q_earliest, it.exp, q_rank, q_bank, q_is_wr);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R10: default configuration is legal
      n_vec++;
      if (cfg_error !== 1'b0) begin
         n_bad++;
         $display("FAIL R10: cfg_error actual %0b expected 0", cfg_error);
      end
      // R1: reset state
      query(0, 0, 0, 0, 0, "R1");
      query(1, 7, 1, 5, 5, "R1");

      // R3: activate rank0 bank1 at 10 -> 22
      act_valid = 1; act_rank = 0; act_bank = 1; act_cycle = 10;
      tick(); act_valid = 0;
      query(0, 1, 0, 0, 22, "R3");
      query(0, 1, 1, 0, 22, "R3");
      query(0, 2, 0, 0, 0, "R3");

      // R7: read rank0 bank1 asked at 20, issues at 22, next burst 26
      col_valid = 1; col_rank = 0; col_bank = 1; col_is_wr = 0; col_cycle = 20;
      tick(); col_valid = 0;
      n_vec++;
      if (next_burst !== 32'd26) begin
         n_bad++;
         $display("FAIL R7: next_burst actual %0d expected 26", next_burst);
      end
      query(0, 2, 0, 0, 28, "R4");
      query(0, 2, 1, 0, 28, "R4");
      query(0, 5, 0, 0, 26, "R5");
      query(0, 5, 1, 0, 28, "R5");
      query(1, 0, 0, 0, 28, "R6");

      // write rank0 bank5: issue 28, next burst 32
      col_valid = 1; col_rank = 0; col_bank = 5; col_is_wr = 1; col_cycle = 0;
      tick(); col_valid = 0;
      query(0, 6, 1, 0, 36, "R4");
      query(0, 6, 0, 0, 46, "R4");
      query(0, 0, 1, 0, 32, "R5");
      query(0, 0, 0, 0, 46, "R5");
      query(1, 3, 0, 0, 34, "R6");

      // R9: power-down exit rank1 at 100
      pd_exit_valid = 1; pd_exit_rank = 1; pd_exit_cycle = 100;
      tick(); pd_exit_valid = 0;
      query(1, 2, 1, 0, 105, "R9");
      query(0, 0, 1, 0, 32, "R9");

      // R8: stale activate does not pull counters back
      act_valid = 1; act_rank = 0; act_bank = 6; act_cycle = 0;
      tick(); act_valid = 0;
      query(0, 6, 1, 0, 36, "R8");

      // R11: activate r0b3 @200 with read r1b0 asked at 110 (issue 110)
      act_valid = 1; act_rank = 0; act_bank = 3; act_cycle = 200;
      col_valid = 1; col_rank = 1; col_bank = 0; col_is_wr = 0; col_cycle = 110;
      tick(); act_valid = 0; col_valid = 0;
      query(0, 3, 0, 0, 212, "R11");
      query(0, 2, 0, 0, 116, "R11");
      query(1, 4, 0, 0, 114, "R11");
      query(1, 1, 1, 0, 116, "R11");

      // R11: activate and write on same bank r1b4 (issue 116 from old counter)
      act_valid = 1; act_rank = 1; act_bank = 4; act_cycle = 110;
      col_valid = 1; col_rank = 1; col_bank = 4; col_is_wr = 1; col_cycle = 0;
      tick(); act_valid = 0; col_valid = 0;
      query(1, 4, 1, 0, 124, "R11");
      query(1, 4, 0, 0, 134, "R11");
      query(1, 0, 1, 0, 120, "R7");
      query(0, 2, 0, 0, 122, "R6");

      // R2: current cycle dominates
      query(0, 2, 0, 500, 500, "R2");

      tick();
      finish_run();
   end
endmodule